// File: doc/BRIEF.md
# Cache miss classification monitor

This block watches a stream of memory reference addresses and gives each accepted reference a cause label. It keeps tags only. Two tag models sit side by side:

- the target cache, which is A-way set-associative;
- a fully associative shadow of the same capacity, which uses true LRU replacement.

A bitmap records which blocks have ever been referenced. Comparing the three lookups tells apart five outcomes: hits, first-time (compulsory) misses, capacity misses, conflict misses, and the rare case where the set-associative cache hits although the shadow misses (anticonflict).

The monitor is placed next to a reference stream for profiling. Each accepted reference yields a registered 3-bit code with a valid strobe one cycle later. Saturating counters keep totals per category. A synchronous clear empties both tag models, the bitmap and the counters, so that a new measurement window starts cold.

Top module: `miss_cause_monitor`

## Requirements
- R1: A reference whose block address lies in the tracked range (below SEEN_BLKS) and has not been referenced since reset or clear gets code 1, whatever either tag model holds.
- R2: A previously seen reference that misses in both the shadow and the target cache gets code 2.
- R3: A previously seen reference that hits in the shadow but misses in the target cache gets code 3.
- R4: A previously seen reference that misses in the shadow but hits in the target cache gets code 4.
- R5: A previously seen reference that hits in both models gets code 0.
- R6: The block address is the reference address shifted right by log2(BLK_BYTES), so offset bits never change the result. The target set is the block address modulo NUM_BLKS/WAYS.
- R7: Each target set replaces its least recently used way, and the shadow replaces its least recently used entry. Both models, and the bitmap, are updated by every accepted reference, including compulsory ones. The code uses the lookups made before that update.
- R8: `out_valid` is high exactly in the cycle after a reference is accepted (`in_valid` high, `clr` low), and `out_class` then holds a code from 0 to 4.
- R9: `cnt_total` counts accepted references, and each per-category counter counts its code. Every counter holds at 2^CNT_W-1 instead of wrapping.
- R10: A cycle with `clr` high empties both tag models and the bitmap, and makes every counter zero in the next cycle. A reference presented in that cycle is dropped.
- R11: A block address at or above SEEN_BLKS is treated as already seen, so it never gets code 1.
- R12: After reset `out_valid` is low and every counter reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of tags, bitmap and counters |
| in_valid | input | 1 | Reference present this cycle |
| in_addr | input | ADDR_W | Byte address of the reference |
| out_valid | output | 1 | Classification code valid |
| out_class | output | 3 | 0 hit, 1 compulsory, 2 capacity, 3 conflict, 4 anticonflict |
| cnt_total | output | CNT_W | Accepted references |
| cnt_hit | output | CNT_W | Code 0 count |
| cnt_first | output | CNT_W | Code 1 count |
| cnt_capacity | output | CNT_W | Code 2 count |
| cnt_conflict | output | CNT_W | Code 3 count |
| cnt_anti | output | CNT_W | Code 4 count |

## Verification
The bench keeps the default geometry: 16-byte blocks, 16 blocks, 4 ways (so 4 sets), a 32-bit address and a 256-block bitmap. Short directed sequences therefore reach each cause:

- five blocks in one set give a conflict;
- seventeen distinct blocks give a capacity miss;
- sixteen blocks kept away from one set give an anticonflict.

The counter width is lowered to 4 bits, so saturation is reached within sixteen references. A long random stream over roughly forty blocks, plus a few out-of-range blocks, is then compared every cycle against a recency-queue model.

// File: rtl/mcm_pkg.sv
// Shared types for the miss-cause monitor.
package mcm_pkg;
    typedef enum logic [2:0] {
        CLS_HIT  = 3'd0,
        CLS_COMP = 3'd1,
        CLS_CAP  = 3'd2,
        CLS_CONF = 3'd3,
        CLS_ANTI = 3'd4
    } cls_e;
    localparam int NUM_CLS = 5;
endpackage

// File: rtl/mcm_lru_set.sv
// Fully associative tag group of N entries with true LRU by age counters.
// Assumes: a lookup tag is stable during the cycle; upd_en applies the lookup.
// Ages of valid entries form a permutation of 0..k-1; invalid entries sit at AGE_MAX.
module mcm_lru_set #(
    parameter int N     = 4,
    parameter int TAG_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [TAG_W-1:0] look_tag,
    input  logic             upd_en,
    output logic             hit
);
    localparam int AGE_W = (N > 1) ? $clog2(N) : 1;
    localparam int VW    = (N > 1) ? $clog2(N) : 1;
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(N - 1);

    logic [N-1:0]       vld;
    logic [TAG_W-1:0]   tags [N];
    logic [AGE_W-1:0]   age  [N];
    logic [N-1:0]       hv;
    logic [AGE_W-1:0]   hit_age;
    logic [VW-1:0]      vic;

    // Tag compare and age of the matching entry.
    always_comb begin
        hit_age = '0;
        for (int i = 0; i < N; i++) begin
            hv[i] = vld[i] && (tags[i] == look_tag);
            if (hv[i]) hit_age = hit_age | age[i];
        end
    end

    // Victim: lowest free entry, else the oldest valid entry.
    always_comb begin
        vic = '0;
        for (int i = 0; i < N; i++)
            if (vld[i] && age[i] == AGE_MAX) vic = VW'(i);
        for (int i = N - 1; i >= 0; i--)
            if (!vld[i]) vic = VW'(i);
    end

    assign hit = |hv;

    // Recency and fill update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            vld <= '0;
            for (int i = 0; i < N; i++) age[i] <= AGE_MAX;
        end else if (upd_en) begin
            for (int i = 0; i < N; i++) begin
                if (hit) begin
                    if (hv[i]) age[i] <= '0;
                    else if (age[i] < hit_age) age[i] <= age[i] + 1'b1;
                end else if (VW'(i) == vic) begin
                    age[i]  <= '0;
                    vld[i]  <= 1'b1;
                    tags[i] <= look_tag;
                end else if (age[i] < AGE_MAX) begin
                    age[i] <= age[i] + 1'b1;
                end
            end
        end
    end

    // R7: a block is never held twice, so at most one entry matches.
    assert_single_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hv));
endmodule

// File: rtl/mcm_seen_map.sv
// First-reference bitmap over block addresses below SEEN_BLKS.
// Assumes: addresses at or above SEEN_BLKS count as already seen.
module mcm_seen_map #(
    parameter int BA_W      = 28,
    parameter int SEEN_BLKS = 256
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic [BA_W-1:0] look,
    input  logic            upd_en,
    output logic            seen
);
    localparam int SW = (SEEN_BLKS > 1) ? $clog2(SEEN_BLKS) : 1;

    logic [SEEN_BLKS-1:0] bits;
    logic                 in_rng;
    logic [SW-1:0]        idx;

    assign in_rng = look < BA_W'(SEEN_BLKS);
    assign idx    = look[SW-1:0];
    assign seen   = !in_rng || bits[idx];

    // Mark a tracked block on use.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) bits <= '0;
        else if (upd_en && in_rng) bits[idx] <= 1'b1;
    end

    // R1: a tracked block is seen after its first accepted reference.
    assert_marked_after_use_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !clr && in_rng) |=> bits[$past(idx)]);
endmodule

// File: rtl/mcm_counters.sv
// Saturating counters: index 0 totals, index 1+k counts class k.
// Assumes: inc_en is high only for accepted references.
module mcm_counters
    import mcm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc_en,
    input  cls_e             cls,
    output logic [CNT_W-1:0] cnt [NUM_CLS+1]
);
    localparam logic [CNT_W-1:0] MAX = '1;

    logic [NUM_CLS:0] bump;

    for (genvar k = 0; k <= NUM_CLS; k++) begin : g_cnt
        if (k == 0) begin : g_tot
            assign bump[k] = inc_en;
        end else begin : g_cls
            assign bump[k] = inc_en && (cls == cls_e'(k - 1));
        end
        // Count one event, holding at the ceiling.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) cnt[k] <= '0;
            else if (bump[k] && cnt[k] != MAX) cnt[k] <= cnt[k] + 1'b1;
        end
    end

    // R9: total holds at the ceiling.
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt[0] == MAX) |=> cnt[0] == MAX);
    // R9: total advances by one per accepted reference below the ceiling.
    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && !clr && cnt[0] != MAX) |=> cnt[0] == $past(cnt[0]) + 1'b1);
    // R10: clear empties the total.
    assert_clear_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt[0] == '0);
endmodule

// File: rtl/miss_cause_monitor.sv
// Miss-cause monitor: labels each accepted reference by comparing a
// set-associative tag model, a fully associative LRU shadow of equal
// capacity and a first-reference bitmap. Code is registered one cycle later.
// Assumes: BLK_BYTES, NUM_BLKS/WAYS are powers of two; WAYS divides NUM_BLKS.
module miss_cause_monitor
    import mcm_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BLK_BYTES = 16,
    parameter int NUM_BLKS  = 16,
    parameter int WAYS      = 4,
    parameter int SEEN_BLKS = 256,
    parameter int CNT_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    output logic [2:0]        out_class,
    output logic [CNT_W-1:0]  cnt_total,
    output logic [CNT_W-1:0]  cnt_hit,
    output logic [CNT_W-1:0]  cnt_first,
    output logic [CNT_W-1:0]  cnt_capacity,
    output logic [CNT_W-1:0]  cnt_conflict,
    output logic [CNT_W-1:0]  cnt_anti
);
    localparam int OFS_W = (BLK_BYTES > 1) ? $clog2(BLK_BYTES) : 1;
    localparam int BA_W  = ADDR_W - OFS_W;
    localparam int SETS  = NUM_BLKS / WAYS;

    logic [BA_W-1:0]  ba;
    logic             unused_ofs;
    logic             acc;
    logic             seen, fa_hit, sa_hit;
    logic [SETS-1:0]  sel, set_hit;
    cls_e             cls_next, cls_q;
    logic [CNT_W-1:0] cnt_arr [NUM_CLS+1];

    assign ba         = in_addr[ADDR_W-1:OFS_W];
    assign unused_ofs = ^in_addr[OFS_W-1:0];
    assign acc        = in_valid && !clr;

    // Target cache: one LRU group per set, selected by block address modulo SETS.
    for (genvar s = 0; s < SETS; s++) begin : g_set
        assign sel[s] = (ba % BA_W'(SETS)) == BA_W'(s);
        mcm_lru_set #(.N(WAYS), .TAG_W(BA_W)) u_set (
            .clk(clk), .rst_n(rst_n), .clr(clr),
            .look_tag(ba), .upd_en(acc && sel[s]), .hit(set_hit[s]));
    end
    assign sa_hit = |(set_hit & sel);

    // Fully associative LRU shadow of equal capacity.
    mcm_lru_set #(.N(NUM_BLKS), .TAG_W(BA_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .look_tag(ba), .upd_en(acc), .hit(fa_hit));

    mcm_seen_map #(.BA_W(BA_W), .SEEN_BLKS(SEEN_BLKS)) u_seen (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .look(ba), .upd_en(acc), .seen(seen));

    // Cause decision from pre-update lookups.
    always_comb begin
        if (!seen)                cls_next = CLS_COMP;
        else if (fa_hit && sa_hit) cls_next = CLS_HIT;
        else if (fa_hit)          cls_next = CLS_CONF;
        else if (sa_hit)          cls_next = CLS_ANTI;
        else                      cls_next = CLS_CAP;
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            cls_q     <= CLS_HIT;
        end else begin
            out_valid <= acc;
            if (acc) cls_q <= cls_next;
        end
    end
    assign out_class = cls_q;

    mcm_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .inc_en(acc), .cls(cls_next), .cnt(cnt_arr));

    assign cnt_total    = cnt_arr[0];
    assign cnt_hit      = cnt_arr[1];
    assign cnt_first    = cnt_arr[2];
    assign cnt_capacity = cnt_arr[3];
    assign cnt_conflict = cnt_arr[4];
    assign cnt_anti     = cnt_arr[5];

    // R8: strobe follows each accepted reference.
    assert_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> out_valid);
    // R8: no strobe without an accepted reference.
    assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !out_valid);
    // R8: only the five defined codes appear.
    assert_code_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_class <= 3'd4);
endmodule

// File: tb/sim_miss_cause_monitor.sv
// Bench: behavioural recency-queue model, compared every cycle.
module sim_miss_cause_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int CW         = 4;
    localparam int NBLK       = 16;
    localparam int NWAY       = 4;
    localparam int NSET       = NBLK / NWAY;
    localparam int NSEEN      = 256;
    localparam int CMAX       = (1 << CW) - 1;

    logic clk = 0, rst_n = 0, clr = 0, in_valid = 0;
    logic [31:0] in_addr = '0;
    logic out_valid;
    logic [2:0] out_class;
    logic [CW-1:0] c_tot, c_hit, c_first, c_cap, c_conf, c_anti;

    miss_cause_monitor #(.CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_addr(in_addr),
        .out_valid(out_valid), .out_class(out_class),
        .cnt_total(c_tot), .cnt_hit(c_hit), .cnt_first(c_first),
        .cnt_capacity(c_cap), .cnt_conflict(c_conf), .cnt_anti(c_anti));

    always #(CLK_PERIOD / 2) clk = ~clk;

    int nchk = 0, nbad = 0;
    bit done = 0;
    int fq[$];
    int sq[$];
    bit seen[NSEEN];
    int ec[6];
    string cls_tag[5] = '{"R5", "R1", "R2", "R3", "R4"};

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void model_clear();
        fq.delete();
        sq.delete();
        for (int i = 0; i < NSEEN; i++) seen[i] = 0;
        for (int i = 0; i < 6; i++) ec[i] = 0;
    endfunction

    function automatic int model(input int ba);
        bit sn;
        int fi, si, n, last, c;
        sn = (ba >= NSEEN) || seen[ba];
        fi = -1;
        si = -1;
        foreach (fq[i]) if (fq[i] == ba) fi = i;
        foreach (sq[i]) if (sq[i] == ba) si = i;
        if (!sn)                     c = 1;
        else if (fi >= 0 && si >= 0) c = 0;
        else if (fi >= 0)            c = 3;
        else if (si >= 0)            c = 4;
        else                         c = 2;
        if (fi >= 0) fq.delete(fi);
        else if (fq.size() == NBLK) void'(fq.pop_back());
        fq.push_front(ba);
        if (si >= 0) sq.delete(si);
        else begin
            n = 0;
            last = -1;
            foreach (sq[i]) if (sq[i] % NSET == ba % NSET) begin n++; last = i; end
            if (n == NWAY) sq.delete(last);
        end
        sq.push_front(ba);
        if (ba < NSEEN) seen[ba] = 1;
        if (ec[0] < CMAX) ec[0]++;
        if (ec[1 + c] < CMAX) ec[1 + c]++;
        return c;
    endfunction

    task automatic check_counts(input string tag);
        check({tag, " total"}, int'(c_tot), ec[0]);
        check({tag, " hit"}, int'(c_hit), ec[1]);
        check({tag, " first"}, int'(c_first), ec[2]);
        check({tag, " capacity"}, int'(c_cap), ec[3]);
        check({tag, " conflict"}, int'(c_conf), ec[4]);
        check({tag, " anti"}, int'(c_anti), ec[5]);
    endtask

    // One reference; want >= 0 adds a directed class check under tag.
    task automatic do_ref(input int ba, input int ofs, input string tag, input int want);
        int e;
        e = model(ba);
        in_valid = 1;
        in_addr  = 32'(ba * 16 + ofs);
        @(negedge clk);
        in_valid = 0;
        check("R8 strobe", int'(out_valid), 1);
        check(cls_tag[e], int'(out_class), e);
        if (want >= 0) check(tag, int'(out_class), want);
        check_counts("R9");
    endtask

    task automatic do_clear();
        model_clear();
        clr = 1;
        in_valid = 1;
        in_addr = 32'h40;
        @(negedge clk);
        clr = 0;
        in_valid = 0;
        check("R10 dropped ref", int'(out_valid), 0);
        check_counts("R10");
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nbad++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
        end
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R12 valid", int'(out_valid), 0);
        check_counts("R12");

        // R1, R6: first use, then same block at another offset.
        do_ref(16, 0, "R1 first", 1);
        do_ref(16, 4, "R6 offset", 0);
        @(negedge clk);
        check("R8 idle", int'(out_valid), 0);

        // R10: clear forgets history.
        do_clear();
        do_ref(16, 4, "R10 cold again", 1);

        // R3, R7: five blocks in set 0.
        do_clear();
        for (int k = 0; k < 5; k++) do_ref(4 * k, 0, "R1 fill", 1);
        do_ref(0, 0, "R3 conflict", 3);
        do_ref(8, 0, "R7 retained", 0);
        do_ref(4, 0, "R7 evicted lru", 3);

        // R2, R9: seventeen distinct blocks then the first again.
        do_clear();
        for (int k = 0; k < 17; k++) do_ref(32 + k, 0, "R1 sweep", 1);
        do_ref(32, 0, "R2 capacity", 2);
        check("R9 first saturated", int'(c_first), CMAX);
        check("R9 total saturated", int'(c_tot), CMAX);

        // R4: keep set 1 untouched while the shadow forgets block 1.
        do_clear();
        do_ref(1, 0, "R1 anchor", 1);
        for (int j = 0; j < 16; j++)
            do_ref(128 + 4 * j + ((j % 3 == 0) ? 0 : (j % 3 == 1) ? 2 : 3), 0, "R1 other", 1);
        do_ref(1, 8, "R4 anticonflict", 4);

        // R11: out-of-range block is never compulsory.
        do_clear();
        do_ref(512, 0, "R11 untracked", 2);
        do_ref(512, 12, "R11 rehit", 0);

        // Random stream.
        do_clear();
        for (int k = 0; k < 600; k++) begin
            int b;
            b = ($urandom_range(0, 19) == 0) ? 300 + int'($urandom_range(0, 3))
                                             : int'($urandom_range(0, 40));
            do_ref(b, int'($urandom_range(0, 15)), "", -1);
        end
        @(negedge clk);
        check("R8 idle end", int'(out_valid), 0);

        done = 1;
        report();
    end
endmodule